// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Whole-Packet Release

This block carries a stream of beats from a producer on one clock to a consumer on an unrelated clock. Each beat holds a data word and an end-of-packet marker. Both sides use the AXI4-Stream valid/ready handshake. The write side accepts beats while storage has room. The read side presents the oldest stored beat.

The write and read positions are kept as binary counters with one extra wrap bit. Each counter is re-encoded in Gray code and registered before it is passed through a two-flop synchroniser into the other clock domain. Full is judged against the delayed read position and empty against the delayed write position. Both flags are therefore pessimistic but always safe.

A compile-time packet mode makes the block store-and-forward. Output valid is held low until a whole packet, ending in a beat with the end marker, has been written. The write domain toggles a flag on every accepted end-marked beat. The read domain synchronises that flag and keeps a count of finished packets that have not yet been read. This count gates the output, so a consumer never starts on a packet whose tail is still missing.

Top module: `axis_cdc_fifo`

## Requirements
- R1: Write and read positions cross clock domains only as registered Gray codes that change by one bit per step. Every accepted beat arrives at the output intact under unrelated clocks and random backpressure on both sides.
- R2: Output beats appear in write order with data and end marker unchanged. Output valid is never high unless at least one written beat is still unread.
- R3: With the reader stalled, exactly 2^ADDR_W beats are accepted, after which input ready is low. The block never holds more than 2^ADDR_W beats.
- R4: A beat moves only on a cycle where its valid and ready are both high. A beat offered while input ready is low is not stored, so it never appears at the output.
- R5: With packet mode off, output valid rises once a beat is stored and its write position has been synchronised, whether or not that beat carries the end marker.
- R6: While output valid is high and output ready is low, output valid stays high and output data and end marker keep their values on the next read clock.
- R7: With packet mode on, no beat of a packet is offered before that packet's end-marked beat has been accepted on the write side. A partial packet keeps output valid low indefinitely.
- R8: With packet mode on, once the end-marked beat is written, output valid rises within 20 read clocks, provided the reader is idle, and the packet drains completely.
- R9: With packet mode on, the count of finished unread packets drops when an end-marked beat leaves the output. After a packet drains, a following partial packet is held back.
- R10: After reset, input ready is high and output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| s_tdata | input | DATA_W | Incoming beat data |
| s_tlast | input | 1 | Incoming end-of-packet marker |
| s_tvalid | input | 1 | Incoming beat is offered |
| s_tready | output | 1 | Room for a beat (not full) |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| m_tdata | output | DATA_W | Outgoing beat data |
| m_tlast | output | 1 | Outgoing end-of-packet marker |
| m_tvalid | output | 1 | Outgoing beat is offered |
| m_tready | input | 1 | Consumer takes the beat |

## Verification
Two instances share the stimulus: one built as a plain stream and one in packet mode. Sending three unmarked beats with the consumer stalled separates the two modes: only the stream instance raises valid. The fourth, end-marked beat then shows when packet-mode release happens.

A fill with the consumer stalled finds the exact capacity and shows that a refused beat is never stored. A partial packet sent after a drain shows that the finished-packet count was decremented. Long runs of random-length packets with random gaps and random consumer stalls on both instances test ordering and marker positions across the clock crossing, and also test hold stability under backpressure.

// File: rtl/axf_pkg.sv
package axf_pkg;
    // Gray re-encoding of a binary count; callers truncate to their width.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/axf_sync.sv
module axf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sy_t;

    sy_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/axf_wr_ctl.sv
module axf_wr_ctl
    import axf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    input  logic        s_last,
    input  logic [AW:0] rgray_sync,
    output logic        s_ready,
    output logic        wen,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wgray,
    output logic        ltog
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          tog;
    } wst_t;

    wst_t st_d, st_q;
    logic full;

    always_comb begin
        // full: top two Gray bits inverted, remaining bits equal
        full = (st_q.gray[PW-1:PW-2] == ~rgray_sync[PW-1:PW-2]) &&
               (st_q.gray[PW-3:0] == rgray_sync[PW-3:0]);
        wen  = s_valid && !full;
        st_d = st_q;
        if (wen) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
            st_d.tog  = st_q.tog ^ s_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_ready = !full;
    assign waddr   = st_q.bin[AW-1:0];
    assign wgray   = st_q.gray;
    assign ltog    = st_q.tog;
endmodule

// File: rtl/axf_rd_ctl.sv
module axf_rd_ctl
    import axf_pkg::*;
#(
    parameter int AW    = 3,
    parameter bit FRAME = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          m_ready,
    input  logic          head_last,
    input  logic [AW:0]   wgray_sync,
    input  logic          tog_sync,
    output logic          m_valid,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray
);
    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          tog_seen;
        logic [AW:0]   frames;
    } rst_t;

    rst_t st_d, st_q;
    logic empty, frame_ok, pop, ev, done_out;

    generate
        if (FRAME) begin : g_frame
            assign frame_ok = (st_q.frames != '0);
        end else begin : g_stream
            assign frame_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        empty    = (st_q.gray == wgray_sync);
        m_valid  = !empty && frame_ok;
        pop      = m_valid && m_ready;
        ev       = tog_sync ^ st_q.tog_seen;
        done_out = pop && head_last;
        st_d          = st_q;
        st_d.tog_seen = tog_sync;
        if (ev && !done_out)      st_d.frames = st_q.frames + 1'b1;
        else if (!ev && done_out) st_d.frames = st_q.frames - 1'b1;
        if (pop) begin
            st_d.bin  = st_q.bin + 1'b1;
            st_d.gray = PW'(to_gray(32'(st_d.bin)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr = st_q.bin[AW-1:0];
    assign rgray = st_q.gray;
endmodule

// File: rtl/axf_store.sv
module axf_store #(
    parameter int AW = 3,
    parameter int EW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    localparam int N = 1 << AW;

    logic [EW-1:0] mem [0:N-1];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/axis_cdc_fifo.sv
module axis_cdc_fifo #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,   // at least 2
    parameter bit FRAME_MODE = 1'b1
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              rclk,
    input  logic              rrst_n,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    localparam int PW = ADDR_W + 1;
    localparam int EW = DATA_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic              tog, tog_s, wen;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [EW-1:0]     rd_word;

    axf_wr_ctl #(.AW(ADDR_W)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .s_valid(s_tvalid), .s_last(s_tlast),
        .rgray_sync(rgray_s), .s_ready(s_tready), .wen(wen), .waddr(waddr),
        .wgray(wgray), .ltog(tog)
    );

    axf_store #(.AW(ADDR_W), .EW(EW)) u_mem (
        .clk(wclk), .we(wen), .waddr(waddr), .wdata({s_tlast, s_tdata}),
        .raddr(raddr), .rdata(rd_word)
    );

    axf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
    axf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
    axf_sync #(.W(1))  u_tog (.clk(rclk), .rst_n(rrst_n), .d(tog),   .q(tog_s));

    axf_rd_ctl #(.AW(ADDR_W), .FRAME(FRAME_MODE)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .m_ready(m_tready), .head_last(rd_word[EW-1]),
        .wgray_sync(wgray_s), .tog_sync(tog_s), .m_valid(m_tvalid),
        .raddr(raddr), .rgray(rgray)
    );

    assign m_tdata = rd_word[DATA_W-1:0];
    assign m_tlast = rd_word[EW-1];
endmodule

// File: rtl/axf_checker.sv
module axf_checker #(
    parameter int DW    = 8,
    parameter int PW    = 4,
    parameter int DEPTH = 8,
    parameter bit FRAME = 1'b1
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          rclk,
    input logic          rrst_n,
    input logic          s_tvalid,
    input logic          s_tready,
    input logic          s_tlast,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic [DW-1:0] m_tdata,
    input logic [PW-1:0] wgray
);
    logic [31:0] wr_cnt, wr_last, rd_cnt, rd_last;

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wr_cnt  <= '0;
            wr_last <= '0;
        end else if (s_tvalid && s_tready) begin
            wr_cnt  <= wr_cnt + 1;
            wr_last <= wr_last + 32'(s_tlast);
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rd_cnt  <= '0;
            rd_last <= '0;
        end else if (m_tvalid && m_tready) begin
            rd_cnt  <= rd_cnt + 1;
            rd_last <= rd_last + 32'(m_tlast);
        end
    end

    p_gray_step_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rrst_n)
        m_tvalid |-> (wr_cnt != rd_cnt));

    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n || !rrst_n)
        (wr_cnt - rd_cnt) <= 32'(DEPTH));

    p_hold_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    p_whole_frame_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
        (FRAME && m_tvalid) |-> (wr_last != rd_last));
endmodule

bind axis_cdc_fifo axf_checker #(
    .DW(DATA_W), .PW(ADDR_W + 1), .DEPTH(1 << ADDR_W), .FRAME(FRAME_MODE)
) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .m_tdata(m_tdata), .wgray(wgray)
);

// File: tb/tb_axis_cdc_fifo.sv
module tb_axis_cdc_fifo;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0;
    always #10 wclk = ~wclk;   // 50 MHz
    always #17 rclk = ~rclk;   // unrelated read clock

    // index 0: plain stream instance, index 1: packet-mode instance
    logic [7:0] s_data [2];
    logic       s_last [2], s_valid [2], s_ready [2];
    logic [7:0] m_data [2];
    logic       m_last [2], m_valid [2], m_ready [2];

    axis_cdc_fifo #(.DATA_W(8), .ADDR_W(AW), .FRAME_MODE(1'b0)) dut_s (
        .wclk(wclk), .wrst_n(wrst_n), .s_tdata(s_data[0]), .s_tlast(s_last[0]),
        .s_tvalid(s_valid[0]), .s_tready(s_ready[0]), .rclk(rclk), .rrst_n(rrst_n),
        .m_tdata(m_data[0]), .m_tlast(m_last[0]), .m_tvalid(m_valid[0]), .m_tready(m_ready[0]));

    axis_cdc_fifo #(.DATA_W(8), .ADDR_W(AW), .FRAME_MODE(1'b1)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .s_tdata(s_data[1]), .s_tlast(s_last[1]),
        .s_tvalid(s_valid[1]), .s_tready(s_ready[1]), .rclk(rclk), .rrst_n(rrst_n),
        .m_tdata(m_data[1]), .m_tlast(m_last[1]), .m_tvalid(m_valid[1]), .m_tready(m_ready[1]));

    int n_chk = 0, n_fail = 0;
    int snk_mode = 0;          // 0 stall, 1 random, 2 always ready
    int fw [2] = '{0, 0};      // packets whose end beat has been accepted
    int q0 [$], q1 [$];        // expected beats: data | last<<8 | packet<<9
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int qsize(input int k);
        return (k == 0) ? q0.size() : q1.size();
    endfunction

    task automatic qpush(input int k, input int v);
        if (k == 0) q0.push_back(v); else q1.push_back(v);
    endtask

    function automatic int qpop(input int k);
        if (k == 0) return q0.pop_front();
        return q1.pop_front();
    endfunction

    // Called at a write-clock falling edge; returns at one.
    task automatic send_lim(input int k, input logic [7:0] d, input logic l,
                            input int lim, output bit ok);
        int waited = 0;
        s_valid[k] = 1'b1; s_data[k] = d; s_last[k] = l;
        ok = 1'b0;
        forever begin
            #1;
            if (s_ready[k]) begin ok = 1'b1; break; end
            if (waited >= lim) break;
            waited++;
            @(negedge wclk);
        end
        if (ok) begin
            qpush(k, int'(d) | (int'(l) << 8) | (fw[k] << 9));
            if (l) fw[k]++;
        end
        @(negedge wclk);
        s_valid[k] = 1'b0;
    endtask

    task automatic send(input int k, input logic [7:0] d, input logic l);
        bit ok;
        send_lim(k, d, l, 100000, ok);
    endtask

    task automatic consume(input int k);
        bit prev_stall = 1'b0;
        logic [7:0] pd = '0;
        logic pl = 1'b0;
        forever begin
            @(negedge rclk);
            m_ready[k] = (snk_mode == 2) || (snk_mode == 1 && ($urandom % 4) != 0);
            #1;
            if (prev_stall)   // R6 hold under backpressure
                check(m_valid[k] && m_data[k] == pd && m_last[k] == pl, "R6",
                      "held beat", int'({m_last[k], m_data[k]}), int'({pl, pd}));
            if (m_valid[k] && m_ready[k]) begin
                if (qsize(k) == 0) begin
                    check(1'b0, "R2", "beat with nothing written", 1, 0);
                end else begin
                    int e = qpop(k);
                    check({m_last[k], m_data[k]} == 9'(e), "R2", "beat order/value",
                          int'({m_last[k], m_data[k]}), e & 32'h1ff);
                    if (k == 1)   // R7 packet must be complete on write side
                        check((e >> 9) < fw[1], "R7", "packet index released",
                              e >> 9, fw[1]);
                end
            end
            prev_stall = m_valid[k] && !m_ready[k];
            pd = m_data[k]; pl = m_last[k];
        end
    endtask

    task automatic rwait(input int n);
        repeat (n) @(negedge rclk);
        @(negedge wclk);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic rand_traffic(input int k);
        for (int f = 0; f < 60; f++) begin
            int len = 3 + int'($urandom % 4);
            for (int b = 0; b < len; b++) begin
                repeat ($urandom % 3) @(negedge wclk);
                send(k, 8'($urandom), b == len - 1);
            end
        end
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            summary;
            $finish;
        end
    end

    initial begin
        bit ok;
        int acc;
        for (int k = 0; k < 2; k++) begin
            s_valid[k] = 1'b0; s_data[k] = '0; s_last[k] = 1'b0; m_ready[k] = 1'b0;
        end
        #200;
        wrst_n = 1'b1; rrst_n = 1'b1;
        fork consume(0); consume(1); join_none
        rwait(4);
        for (int k = 0; k < 2; k++) begin
            check(s_ready[k] == 1'b1, "R10", "input ready after reset", s_ready[k], 1);
            check(m_valid[k] == 1'b0, "R10", "output valid after reset", m_valid[k], 0);
        end

        // partial packet with consumer stalled
        for (int k = 0; k < 2; k++) begin
            send(k, 8'h11, 1'b0); send(k, 8'h12, 1'b0); send(k, 8'h13, 1'b0);
        end
        rwait(20);
        check(m_valid[0] == 1'b1, "R5", "stream valid without end beat", m_valid[0], 1);
        check(m_valid[1] == 1'b0, "R7", "packet mode withholds partial", m_valid[1], 0);
        for (int k = 0; k < 2; k++) send(k, 8'h14, 1'b1);
        rwait(20);
        check(m_valid[1] == 1'b1, "R8", "packet released after end beat", m_valid[1], 1);
        snk_mode = 2;
        rwait(30);
        check(qsize(0) == 0, "R2", "stream drained", qsize(0), 0);
        check(qsize(1) == 0, "R8", "packet drained", qsize(1), 0);

        // second partial packet after a drain
        for (int k = 0; k < 2; k++) begin
            send(k, 8'h21, 1'b0); send(k, 8'h22, 1'b0);
        end
        rwait(20);
        check(m_valid[1] == 1'b0, "R9", "partial held after drain", m_valid[1], 0);
        check(qsize(1) == 2, "R9", "beats still stored", qsize(1), 2);
        check(qsize(0) == 0, "R5", "stream passed partial", qsize(0), 0);
        for (int k = 0; k < 2; k++) send(k, 8'h23, 1'b1);
        rwait(20);
        check(qsize(1) == 0, "R8", "second packet drained", qsize(1), 0);

        // capacity with stalled consumer (stream instance)
        snk_mode = 0;
        rwait(2);
        acc = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            send_lim(0, 8'(8'h30 + i), 1'b0, 20, ok);
            if (!ok) break;
            acc++;
        end
        check(acc == DEPTH, "R3", "beats accepted when stalled", acc, DEPTH);
        check(s_ready[0] == 1'b0, "R3", "input ready when full", s_ready[0], 0);
        snk_mode = 2;
        rwait(40);
        check(qsize(0) == 0, "R4", "refused beat never emitted", qsize(0), 0);
        check(m_valid[0] == 1'b0, "R4", "no extra beat after drain", m_valid[0], 0);

        // random traffic with backpressure on both sides
        snk_mode = 1;
        fork rand_traffic(0); rand_traffic(1); join
        for (int i = 0; i < 4000 && (qsize(0) + qsize(1)) != 0; i++) @(negedge rclk);
        rwait(4);
        check(qsize(0) == 0, "R1", "stream random run delivered", qsize(0), 0);
        check(qsize(1) == 0, "R1", "packet random run delivered", qsize(1), 0);
        check(fw[1] == 62, "R7", "packets written", fw[1], 62);

        done = 1'b1;
        summary;
        $finish;
    end
endmodule